// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the entry steps for an interrupt on a small 16-bit processor core. While idle it looks at seven level-coded request lines and at the current interrupt mask. It picks the highest pending level, and accepts that level only when it is above the mask. Level 7 is always accepted. Once a request is accepted, the block runs a fixed sequence:

1. It writes the program counter to the stack.
2. It writes the condition word to the stack.
3. It clears the program-bank extension field.
4. It loads the mask with the level being serviced.
5. It runs an acknowledge bus cycle.
6. It turns the vector number into a table address.
7. It fetches the handler address and loads it into the program counter.

The acknowledge cycle ends in one of three ways. The device may return its own vector number. It may ask for an autovector, which is a fixed base plus the level. A bus error forces a fixed spurious vector instead. Each vector-table entry is one 16-bit word, so the table address is the vector number times two.

The processor keeps its own mask, bank and program-counter registers. The block reads their current values and changes them only through single-cycle write strobes. While a sequence is running, `busy_o` is high and no new request is sampled.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_ni` is low, and after reset until a request is accepted, `busy_o`, `stk_we_o`, `bank_clr_o`, `mask_we_o`, `iack_o`, `vf_req_o` and `pc_we_o` are all low.
- R2: Bit i-1 of `req_i` is a request at level i. The highest level present is the one serviced. Both `mask_o` (during the mask load) and `iack_lvl_o` carry that level.
- R3: Requests are sampled only while idle. A level is accepted when it is above `cur_mask_i`, and level 7 is accepted whatever the mask. `busy_o` is high in the cycle after the sampling edge.
- R4: After acceptance the strobes follow a fixed order, with at most one high per cycle:
  - one cycle of program-counter stacking;
  - one cycle of condition-word stacking;
  - one cycle of `bank_clr_o`;
  - one cycle of `mask_we_o`;
  - `iack_o` until a response arrives;
  - one address cycle with no strobe;
  - `vf_req_o` until `vf_ack_i`;
  - one cycle of `pc_we_o`.
- R5: The first stack write has `stk_sel_o`=0 and carries `cur_pc_i`. The second has `stk_sel_o`=1 and carries the condition word. In that word, bits [2:0] hold `cur_mask_i`, bits [6:3] hold `cur_bank_i`, and the upper bits are zero. Both values are taken before the bank clear and the mask load.
- R6: When the acknowledge cycle ends on `iack_dtack_i` alone, `iack_vec_i` is the vector number.
- R7: When `iack_avec_i` is high without `iack_berr_i`, the vector number is `AVEC_BASE` plus the level (0x18 plus the level by default). This takes priority over `iack_dtack_i`.
- R8: When `iack_berr_i` is high, the vector number is `SPUR_VEC` (0x0F by default), whatever the other two response inputs show.
- R9: `vf_addr_o` is the vector number times two, zero-extended to 16 bits, and it stays constant while `vf_req_o` is high.
- R10: `pc_o` equals the `vf_data_i` word taken with `vf_ack_i`. `pc_we_o` is high for exactly the one cycle after that acknowledge.
- R11: `busy_o` stays high from the cycle after acceptance through the program-counter load cycle, and is low in the cycle after it. Changes on `req_i` during that time do not change the running sequence. A request that is withdrawn before the sequence ends is never accepted.
- R12: With no request pending, or with every pending level at or below the mask and below 7, the block stays idle and drives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 7 | Level-coded requests; bit i-1 is level i |
| cur_mask_i | input | 3 | Current interrupt mask of the core |
| cur_bank_i | input | 4 | Current program-bank extension field |
| cur_pc_i | input | 16 | Current program counter |
| busy_o | output | 1 | Entry sequence in progress |
| stk_we_o | output | 1 | Stack write strobe |
| stk_sel_o | output | 1 | Stack word select: 0 is the program counter, 1 is the condition word |
| stk_data_o | output | 16 | Stack write data |
| bank_clr_o | output | 1 | Clear the program-bank extension field |
| mask_we_o | output | 1 | Mask write strobe |
| mask_o | output | 3 | New mask value |
| iack_o | output | 1 | Acknowledge cycle active |
| iack_lvl_o | output | 3 | Level being acknowledged |
| iack_vec_i | input | 8 | Vector number driven by the device |
| iack_dtack_i | input | 1 | Device has placed its vector on `iack_vec_i` |
| iack_avec_i | input | 1 | Device requests an autovector |
| iack_berr_i | input | 1 | Bus error during the acknowledge cycle |
| vf_req_o | output | 1 | Vector-table read request |
| vf_addr_o | output | 16 | Vector-table address |
| vf_data_i | input | 16 | Vector-table read data |
| vf_ack_i | input | 1 | Vector-table read done |
| pc_we_o | output | 1 | Program-counter write strobe |
| pc_o | output | 16 | Handler address |

## Verification
The assertions rely on a well-behaved environment:
- The response inputs are asserted only while `iack_o` is high.
- `vf_ack_i` comes only with `vf_req_o`.
- The processor's mask, bank and program-counter registers follow the strobes of this block.

The bench keeps to these conditions. It models those three registers from the strobes. It drives an acknowledge response only after it has seen `iack_o` at a falling edge, and it drives a table acknowledge only after it has seen `vf_req_o`, removing each after one cycle. It also withdraws every request before the program-counter load, so that the new mask alone decides whether the block goes back to idle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STK_PC,
    ST_STK_CCR,
    ST_CLR_BANK,
    ST_LD_MASK,
    ST_IACK,
    ST_VEC_ADDR,
    ST_FETCH,
    ST_LD_PC
  } seq_state_e;

  typedef enum logic [1:0] {
    RESP_NONE,
    RESP_DEV,
    RESP_AUTO,
    RESP_SPUR
  } iack_resp_e;

endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
  parameter int LVL_W = 3
) (
  input  logic [(1<<LVL_W)-2:0] req_i,
  input  logic [LVL_W-1:0]      mask_i,
  output logic                  vld_o,
  output logic [LVL_W-1:0]      lvl_o
);
  localparam int NUM_REQ = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_REQ);

  // Per-level candidate: level if requested, else zero; highest wins.
  logic [LVL_W-1:0] cand [NUM_REQ+1];

  assign cand[0] = '0;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_lvl
    assign cand[g+1] = req_i[g] ? LVL_W'(g + 1) : cand[g];
  end

  assign lvl_o = cand[NUM_REQ];
  assign vld_o = (lvl_o != '0) && ((lvl_o > mask_i) || (lvl_o == NMI_LVL));

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_entry_pkg::*;
#(
  parameter int                LVL_W     = 3,
  parameter int                VEC_W     = 8,
  parameter logic [VEC_W-1:0]  AVEC_BASE = 'h18,
  parameter logic [VEC_W-1:0]  SPUR_VEC  = 'h0F
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0] dev_vec_i,
  input  logic             dtack_i,
  input  logic             avec_i,
  input  logic             berr_i,
  output iack_resp_e       resp_o,
  output logic [VEC_W-1:0] vec_o
);

  // Bus error dominates, then autovector, then device vector.
  always_comb begin
    if (berr_i) begin
      resp_o = RESP_SPUR;
      vec_o  = SPUR_VEC;
    end else if (avec_i) begin
      resp_o = RESP_AUTO;
      vec_o  = AVEC_BASE + VEC_W'(lvl_i);
    end else if (dtack_i) begin
      resp_o = RESP_DEV;
      vec_o  = dev_vec_i;
    end else begin
      resp_o = RESP_NONE;
      vec_o  = '0;
    end
  end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int BANK_W = 4,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pick_vld_i,
  input  logic [LVL_W-1:0]  pick_lvl_i,
  input  iack_resp_e        resp_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [LVL_W-1:0]  cur_mask_i,
  input  logic [BANK_W-1:0] cur_bank_i,
  input  logic [DATA_W-1:0] cur_pc_i,
  input  logic [DATA_W-1:0] vf_data_i,
  input  logic              vf_ack_i,
  output logic              busy_o,
  output logic              stk_we_o,
  output logic              stk_sel_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              bank_clr_o,
  output logic              mask_we_o,
  output logic              iack_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              vf_req_o,
  output logic [DATA_W-1:0] vf_addr_o,
  output logic              pc_we_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam int CCR_W = LVL_W + BANK_W;

  seq_state_e        state_q, state_d;
  logic [LVL_W-1:0]  lvl_q;
  logic [VEC_W-1:0]  vec_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] hdl_q;
  logic [CCR_W-1:0]  ccr_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (pick_vld_i) state_d = ST_STK_PC;
      ST_STK_PC:   state_d = ST_STK_CCR;
      ST_STK_CCR:  state_d = ST_CLR_BANK;
      ST_CLR_BANK: state_d = ST_LD_MASK;
      ST_LD_MASK:  state_d = ST_IACK;
      ST_IACK:     if (resp_i != RESP_NONE) state_d = ST_VEC_ADDR;
      ST_VEC_ADDR: state_d = ST_FETCH;
      ST_FETCH:    if (vf_ack_i) state_d = ST_LD_PC;
      ST_LD_PC:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      vec_q   <= '0;
      addr_q  <= '0;
      hdl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && pick_vld_i)            lvl_q  <= pick_lvl_i;
      if (state_q == ST_IACK && resp_i != RESP_NONE)   vec_q  <= vec_i;
      if (state_q == ST_VEC_ADDR)                      addr_q <= DATA_W'({vec_q, 1'b0});
      if (state_q == ST_FETCH && vf_ack_i)             hdl_q  <= vf_data_i;
    end
  end

  assign ccr_word   = {cur_bank_i, cur_mask_i};

  assign busy_o     = (state_q != ST_IDLE);
  assign stk_we_o   = (state_q == ST_STK_PC) || (state_q == ST_STK_CCR);
  assign stk_sel_o  = (state_q == ST_STK_CCR);
  assign stk_data_o = (state_q == ST_STK_PC) ? cur_pc_i : DATA_W'(ccr_word);
  assign bank_clr_o = (state_q == ST_CLR_BANK);
  assign mask_we_o  = (state_q == ST_LD_MASK);
  assign iack_o     = (state_q == ST_IACK);
  assign lvl_o      = lvl_q;
  assign vf_req_o   = (state_q == ST_FETCH);
  assign vf_addr_o  = addr_q;
  assign pc_we_o    = (state_q == ST_LD_PC);
  assign pc_o       = hdl_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int               LVL_W     = 3,
  parameter int               BANK_W    = 4,
  parameter int               DATA_W    = 16,
  parameter int               VEC_W     = 8,
  parameter logic [VEC_W-1:0] AVEC_BASE = 'h18,
  parameter logic [VEC_W-1:0] SPUR_VEC  = 'h0F
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [(1<<LVL_W)-2:0] req_i,
  input  logic [LVL_W-1:0]      cur_mask_i,
  input  logic [BANK_W-1:0]     cur_bank_i,
  input  logic [DATA_W-1:0]     cur_pc_i,
  output logic                  busy_o,
  output logic                  stk_we_o,
  output logic                  stk_sel_o,
  output logic [DATA_W-1:0]     stk_data_o,
  output logic                  bank_clr_o,
  output logic                  mask_we_o,
  output logic [LVL_W-1:0]      mask_o,
  output logic                  iack_o,
  output logic [LVL_W-1:0]      iack_lvl_o,
  input  logic [VEC_W-1:0]      iack_vec_i,
  input  logic                  iack_dtack_i,
  input  logic                  iack_avec_i,
  input  logic                  iack_berr_i,
  output logic                  vf_req_o,
  output logic [DATA_W-1:0]     vf_addr_o,
  input  logic [DATA_W-1:0]     vf_data_i,
  input  logic                  vf_ack_i,
  output logic                  pc_we_o,
  output logic [DATA_W-1:0]     pc_o
);

  logic             pick_vld;
  logic [LVL_W-1:0] pick_lvl;
  logic [LVL_W-1:0] svc_lvl;
  iack_resp_e       resp;
  logic [VEC_W-1:0] vec_num;

  irq_lvl_pick #(
    .LVL_W (LVL_W)
  ) i_pick (
    .req_i  (req_i),
    .mask_i (cur_mask_i),
    .vld_o  (pick_vld),
    .lvl_o  (pick_lvl)
  );

  irq_vec_gen #(
    .LVL_W     (LVL_W),
    .VEC_W     (VEC_W),
    .AVEC_BASE (AVEC_BASE),
    .SPUR_VEC  (SPUR_VEC)
  ) i_vec (
    .lvl_i     (svc_lvl),
    .dev_vec_i (iack_vec_i),
    .dtack_i   (iack_dtack_i),
    .avec_i    (iack_avec_i),
    .berr_i    (iack_berr_i),
    .resp_o    (resp),
    .vec_o     (vec_num)
  );

  irq_entry_ctl #(
    .LVL_W  (LVL_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W)
  ) i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pick_vld_i (pick_vld),
    .pick_lvl_i (pick_lvl),
    .resp_i     (resp),
    .vec_i      (vec_num),
    .cur_mask_i (cur_mask_i),
    .cur_bank_i (cur_bank_i),
    .cur_pc_i   (cur_pc_i),
    .vf_data_i  (vf_data_i),
    .vf_ack_i   (vf_ack_i),
    .busy_o     (busy_o),
    .stk_we_o   (stk_we_o),
    .stk_sel_o  (stk_sel_o),
    .stk_data_o (stk_data_o),
    .bank_clr_o (bank_clr_o),
    .mask_we_o  (mask_we_o),
    .iack_o     (iack_o),
    .lvl_o      (svc_lvl),
    .vf_req_o   (vf_req_o),
    .vf_addr_o  (vf_addr_o),
    .pc_we_o    (pc_we_o),
    .pc_o       (pc_o)
  );

  assign mask_o     = svc_lvl;
  assign iack_lvl_o = svc_lvl;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int               LVL_W     = 3,
  parameter int               DATA_W    = 16,
  parameter int               VEC_W     = 8,
  parameter logic [VEC_W-1:0] AVEC_BASE = 'h18,
  parameter logic [VEC_W-1:0] SPUR_VEC  = 'h0F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              stk_we_o,
  input logic              stk_sel_o,
  input logic              bank_clr_o,
  input logic              mask_we_o,
  input logic [LVL_W-1:0]  mask_o,
  input logic              iack_o,
  input logic [LVL_W-1:0]  iack_lvl_o,
  input logic [VEC_W-1:0]  iack_vec_i,
  input logic              iack_dtack_i,
  input logic              iack_avec_i,
  input logic              iack_berr_i,
  input logic              vf_req_o,
  input logic [DATA_W-1:0] vf_addr_o,
  input logic [DATA_W-1:0] vf_data_i,
  input logic              vf_ack_i,
  input logic              pc_we_o,
  input logic [DATA_W-1:0] pc_o
);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stk_we_o, bank_clr_o, mask_we_o, iack_o, vf_req_o, pc_we_o})); // R4

  AST_STACK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> stk_we_o && !stk_sel_o); // R4

  AST_CCR_AFTER_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o && stk_sel_o |-> $past(stk_we_o && !stk_sel_o)); // R5

  AST_CLR_AFTER_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_clr_o |-> $past(stk_we_o && stk_sel_o)); // R4

  AST_MASK_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |-> $past(bank_clr_o)); // R4

  AST_IACK_LVL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |=> iack_o && iack_lvl_o == $past(mask_o)); // R2

  AST_DEV_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o && iack_dtack_i && !iack_avec_i && !iack_berr_i
    |-> ##2 vf_req_o && vf_addr_o == DATA_W'({$past(iack_vec_i, 2), 1'b0})); // R6

  AST_AUTO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o && iack_avec_i && !iack_berr_i
    |-> ##2 vf_req_o && vf_addr_o == DATA_W'({AVEC_BASE + VEC_W'($past(iack_lvl_o, 2)), 1'b0})); // R7

  AST_SPUR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o && iack_berr_i |-> ##2 vf_req_o && vf_addr_o == DATA_W'({SPUR_VEC, 1'b0})); // R8

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_req_o && $past(vf_req_o) |-> $stable(vf_addr_o)); // R9

  AST_PC_FROM_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> $past(vf_req_o && vf_ack_i) && pc_o == $past(vf_data_i)); // R10

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !pc_we_o |=> busy_o); // R11

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> !busy_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(stk_we_o || bank_clr_o || mask_we_o || iack_o || vf_req_o || pc_we_o)); // R12

endmodule

bind irq_entry_seq irq_entry_chk #(
  .LVL_W     (LVL_W),
  .DATA_W    (DATA_W),
  .VEC_W     (VEC_W),
  .AVEC_BASE (AVEC_BASE),
  .SPUR_VEC  (SPUR_VEC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .stk_we_o     (stk_we_o),
  .stk_sel_o    (stk_sel_o),
  .bank_clr_o   (bank_clr_o),
  .mask_we_o    (mask_we_o),
  .mask_o       (mask_o),
  .iack_o       (iack_o),
  .iack_lvl_o   (iack_lvl_o),
  .iack_vec_i   (iack_vec_i),
  .iack_dtack_i (iack_dtack_i),
  .iack_avec_i  (iack_avec_i),
  .iack_berr_i  (iack_berr_i),
  .vf_req_o     (vf_req_o),
  .vf_addr_o    (vf_addr_o),
  .vf_data_i    (vf_data_i),
  .vf_ack_i     (vf_ack_i),
  .pc_we_o      (pc_we_o),
  .pc_o         (pc_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] AVEC_BASE = 8'h18;
  localparam logic [7:0] SPUR_VEC  = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [6:0]  req = '0;
  logic [2:0]  mask_r = '0;
  logic [3:0]  bank_r = '0;
  logic [15:0] pc_r = '0;
  logic        busy, stk_we, stk_sel, bank_clr, mask_we, iack, vf_req, pc_we;
  logic [15:0] stk_data, vf_addr, pc_val;
  logic [2:0]  mask_val, iack_lvl;
  logic [7:0]  dvec = '0;
  logic        dtack = 1'b0, avec = 1'b0, berr = 1'b0;
  logic [15:0] vf_data = '0;
  logic        vf_ack = 1'b0;

  irq_entry_seq i_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .cur_mask_i(mask_r), .cur_bank_i(bank_r), .cur_pc_i(pc_r),
    .busy_o(busy), .stk_we_o(stk_we), .stk_sel_o(stk_sel), .stk_data_o(stk_data),
    .bank_clr_o(bank_clr), .mask_we_o(mask_we), .mask_o(mask_val),
    .iack_o(iack), .iack_lvl_o(iack_lvl), .iack_vec_i(dvec),
    .iack_dtack_i(dtack), .iack_avec_i(avec), .iack_berr_i(berr),
    .vf_req_o(vf_req), .vf_addr_o(vf_addr), .vf_data_i(vf_data), .vf_ack_i(vf_ack),
    .pc_we_o(pc_we), .pc_o(pc_val)
  );

  // Model of the core's registers, following the strobes.
  logic        ld_en = 1'b0;
  logic [2:0]  ld_mask = '0;
  logic [3:0]  ld_bank = '0;
  logic [15:0] ld_pc = '0;
  always @(posedge clk) begin
    if (ld_en) begin
      mask_r <= ld_mask; bank_r <= ld_bank; pc_r <= ld_pc;
    end else begin
      if (mask_we)  mask_r <= mask_val;
      if (bank_clr) bank_r <= '0;
      if (pc_we)    pc_r   <= pc_val;
    end
  end

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       req;
  } ev_t;
  ev_t exp_q[$];

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [15:0] v, input string rq);
    ev_t e;
    e.kind = k; e.val = v; e.req = rq;
    exp_q.push_back(e);
  endtask

  task automatic got(input int k, input logic [15:0] v);
    ev_t e;
    if (exp_q.size() == 0) begin
      check("R11", {k[15:0], v}, 32'h0, "unexpected event");
    end else begin
      e = exp_q.pop_front();
      check(e.req, {k[15:0], v}, {e.kind[15:0], e.val}, "event kind/value");
    end
  endtask

  // Monitor: kinds 1 stack pc, 2 stack ccr, 3 bank clear, 4 mask, 5 iack, 6 fetch, 7 pc load
  logic iack_d = 1'b0, vf_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stk_we)          got(stk_sel ? 2 : 1, stk_data);
      if (bank_clr)        got(3, 16'h0);
      if (mask_we)         got(4, {13'h0, mask_val});
      if (iack && !iack_d) got(5, {13'h0, iack_lvl});
      if (vf_req && !vf_d) got(6, vf_addr);
      if (pc_we)           got(7, pc_val);
    end
    iack_d = iack;
    vf_d   = vf_req;
  end

  function automatic logic [2:0] top_lvl(input logic [6:0] r);
    logic [2:0] l = '0;
    for (int i = 0; i < 7; i++) if (r[i]) l = 3'(i + 1);
    return l;
  endfunction

  function automatic logic [6:0] strobes();
    return {busy, stk_we, bank_clr, mask_we, iack, vf_req, pc_we};
  endfunction

  // resp: 0 device vector, 1 autovector, 2 bus error, 3 all three at once
  task automatic run_irq(input logic [6:0] r, input logic [2:0] msk, input logic [3:0] bnk,
                         input logic [15:0] pc, input int resp, input logic [7:0] dv,
                         input logic [15:0] hdl, input int wait_n, input bit glitch);
    logic [2:0]  lvl;
    bit          acc;
    logic [7:0]  vec;
    string       vrq;
    ld_en = 1'b1; ld_mask = msk; ld_bank = bnk; ld_pc = pc;
    @(negedge clk);
    ld_en = 1'b0;
    lvl = top_lvl(r);
    acc = (lvl != 0) && ((lvl > msk) || (lvl == 3'd7));
    if (acc) begin
      case (resp)
        0:       begin vec = dv;               vrq = "R6 R9"; end
        1:       begin vec = AVEC_BASE + 8'(lvl); vrq = "R7 R9"; end
        default: begin vec = SPUR_VEC;         vrq = "R8 R9"; end
      endcase
      push(1, pc, "R5");
      push(2, 16'({bnk, msk}), "R5");
      push(3, 16'h0, "R4");
      push(4, {13'h0, lvl}, "R2");
      push(5, {13'h0, lvl}, "R2");
      push(6, 16'({vec, 1'b0}), vrq);
      push(7, hdl, "R10");
    end
    req = r;
    @(negedge clk);
    check("R3", {31'h0, busy}, {31'h0, acc}, "busy after sampling");
    if (!acc) begin
      repeat (4) begin
        @(negedge clk);
        check("R12", {25'h0, strobes()}, 32'h0, "idle with masked/empty request");
      end
      req = '0;
      return;
    end
    if (glitch) req = 7'h7F;
    while (!iack) @(negedge clk);
    repeat (wait_n) @(negedge clk);
    dvec  = dv;
    dtack = (resp == 0) || (resp == 3);
    avec  = (resp == 1) || (resp == 3);
    berr  = (resp >= 2);
    @(negedge clk);
    dtack = 1'b0; avec = 1'b0; berr = 1'b0;
    while (!vf_req) @(negedge clk);
    req = '0;
    vf_data = hdl;
    vf_ack  = 1'b1;
    @(negedge clk);
    vf_ack = 1'b0;
    check("R11", {31'h0, busy}, 32'h1, "busy during pc load");
    @(negedge clk);
    check("R11", {31'h0, busy}, 32'h0, "busy after pc load");
    check("R10", {16'h0, pc_r}, {16'h0, hdl}, "pc register");
    check("R2", {29'h0, mask_r}, {29'h0, lvl}, "mask register");
    check("R4", {28'h0, bank_r}, 32'h0, "bank cleared");
    check("R4", exp_q.size(), 32'h0, "events outstanding");
    if (glitch) begin
      repeat (3) begin
        @(negedge clk);
        check("R11", {25'h0, strobes()}, 32'h0, "withdrawn request not taken");
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {25'h0, strobes()}, 32'h0, "outputs in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {25'h0, strobes()}, 32'h0, "outputs after reset");

    run_irq(7'b0000100, 3'd0, 4'hA, 16'h2000, 0, 8'h40, 16'h1234, 0, 1'b0);
    run_irq(7'b0110010, 3'd1, 4'h5, 16'h3456, 1, 8'h00, 16'hBEEF, 1, 1'b0);
    run_irq(7'b0001000, 3'd4, 4'h1, 16'h0100, 0, 8'h00, 16'h0000, 0, 1'b0);
    run_irq(7'b0000010, 3'd5, 4'h1, 16'h0100, 0, 8'h00, 16'h0000, 0, 1'b0);
    run_irq(7'b0000000, 3'd0, 4'h1, 16'h0100, 0, 8'h00, 16'h0000, 0, 1'b0);
    run_irq(7'b1000001, 3'd7, 4'hF, 16'hFFFE, 3, 8'h77, 16'h0F0F, 2, 1'b0);
    run_irq(7'b0000010, 3'd0, 4'h3, 16'h4444, 0, 8'hFF, 16'hA5A5, 0, 1'b1);
    run_irq(7'b0000001, 3'd0, 4'h0, 16'h0002, 1, 8'h00, 16'h5555, 3, 1'b0);
    run_irq(7'b0100000, 3'd2, 4'h7, 16'h8000, 2, 8'h33, 16'h7FFE, 1, 1'b0);

    check("R4", exp_q.size(), 32'h0, "final queue empty");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule